// File: doc/BRIEF.md
# Configurable SPI Master Engine

This block runs one SPI transfer at a time as the master. A start strobe hands it a 32-bit payload together with the settings for that transfer: a 16-bit clock divider, a bit count, the SCLK edge on which MOSI changes, the SCLK edge on which MISO is sampled, and a 2-bit index that picks one of four targets. The engine drives the chosen active-low chip select, generates SCLK from the system clock, shifts the payload out MSB first and shifts the returned bits into a capture register.

When a transfer ends, the low 24 bits of the capture register become the response word. The response word is held until the next transfer finishes. A ready flag tells the surrounding logic when a new start strobe will be accepted. Register decoding in front of the engine and the mapping of its signals onto device pins are handled elsewhere.

Top module: `spiEngine`

## Requirements
- R1: While reset (`rstN` low) is applied and right after it is released, `ready` is 1, `csN` is 4'b1111, `sclk` is 0, `mosi` is 0 and `response` is 0.
- R2: One bit period lasts P = `clkDiv`+1 system clocks, and a divider of 0 behaves as 1. SCLK is high for floor(P/2) cycles from each rising edge, and low for the rest of the period.
- R3: The bit count N is `xferLen`. A value of 0, or any value above 32, means 32. The N bits sent are `startData[31]` down to `startData[32-N]`, MSB first, and the lower bits are never sent.
- R4: With `mosiOnRise`=0, MOSI shows bit 0 from chip-select assertion and changes only on falling SCLK edges. With `mosiOnRise`=1, MOSI changes only on rising SCLK edges, starting at the second one. In both cases the target reads each bit on the opposite edge.
- R5: With `misoOnRise`=1, MISO is sampled on each rising SCLK edge. With `misoOnRise`=0, it is sampled on each falling edge. Exactly N samples are shifted in, MSB first.
- R6: When the chip select is released, `response` takes the low 24 bits of the capture register, so the last min(N,24) received bits sit right-aligned and higher bits are zero. The value then stays fixed until the next transfer completes.
- R7: `ready` is 1 only in idle. It goes to 0 in the cycle after a start is accepted and returns to 1 in the same cycle the chip select is released. A start strobe seen while `ready` is 0 is ignored.
- R8: `targetSel` value k drives only `csN[k]` low for the transfer. The other three chip selects stay high.
- R9: The first rising SCLK edge comes P cycles after the chip select falls. There are exactly N rising edges, and the chip select stays low for exactly (N+2)·P cycles.
- R10: While every chip select is high, `sclk` and `mosi` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | Start request, taken only when ready |
| startData | input | 32 | Payload, MSB-aligned |
| clkDiv | input | 16 | Bit period minus one |
| xferLen | input | 6 | Bit count (0 means 32) |
| mosiOnRise | input | 1 | 1: MOSI changes on rising SCLK edges |
| misoOnRise | input | 1 | 1: MISO sampled on rising SCLK edges |
| targetSel | input | 2 | Target index |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| csN | output | 4 | Active-low chip selects |
| miso | input | 1 | Serial data in |
| ready | output | 1 | Engine idle and able to accept a start |
| response | output | 24 | Low 24 captured bits of the last completed transfer |

## Verification
After an accepted start, `ready` is due low one cycle later and the chip select falls in that same cycle. The first SCLK rise follows P cycles later, and the chip select rises with `ready` and the new `response` exactly (N+2)·P cycles after it fell.

A driver queues the expected item for each transfer. A monitor samples on falling clock edges, counts cycles from the chip-select fall, and compares the lead time, the first high time, the edge count, the shifted bits, the total low time and the response against that item at those exact counts. The monitor also models the target: it drives MISO on the edge opposite the capture edge.

// File: rtl/spiEnginePkg.sv
package spiEnginePkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_BITS  = 2'd2,
    ST_TRAIL = 2'd3
  } engState_t;

  // Per-cycle commands from control to datapath
  typedef struct packed {
    logic load;      // accept start: latch payload, assert chip select
    logic rise;      // SCLK rising edge at this clock
    logic fall;      // SCLK falling edge at this clock
    logic leadRise;  // the rising edge that opens bit 0
    logic lastBit;   // current bit is the final one
    logic finish;    // release chip select, publish response
  } engStrobes_t;

endpackage

// File: rtl/spiEngineCtrl.sv
module spiEngineCtrl
  import spiEnginePkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int LEN_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startStb,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic [LEN_W-1:0] xferLen,
  output logic             ready,
  output engStrobes_t      stb
);

  localparam int IDX_W = $clog2(DATA_W);

  engState_t        state;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] pLast;
  logic [DIV_W-1:0] halfLast;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] lastIdx;

  logic [DIV_W-1:0] pLastNext;
  logic [DIV_W:0]   halfNext;
  logic [IDX_W-1:0] lastIdxNext;
  logic             atEnd;

  // Settings computed from the start inputs
  always_comb begin
    pLastNext = (clkDiv == '0) ? DIV_W'(1) : clkDiv;
    halfNext  = ({1'b0, pLastNext} + (DIV_W+1)'(1)) >> 1;
    if (xferLen == '0 || int'(xferLen) > DATA_W)
      lastIdxNext = IDX_W'(DATA_W - 1);
    else
      lastIdxNext = IDX_W'(xferLen - LEN_W'(1));
  end

  assign atEnd = (cnt == pLast);
  assign ready = (state == ST_IDLE);

  always_comb begin
    stb          = '0;
    stb.load     = (state == ST_IDLE) && startStb;
    stb.lastBit  = (bitIdx == lastIdx);
    stb.leadRise = (state == ST_LEAD) && atEnd;
    stb.rise     = stb.leadRise || ((state == ST_BITS) && atEnd && !stb.lastBit);
    stb.fall     = (state == ST_BITS) && (cnt == halfLast);
    stb.finish   = (state == ST_TRAIL) && atEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      pLast    <= DIV_W'(1);
      halfLast <= '0;
      bitIdx   <= '0;
      lastIdx  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startStb) begin
            state    <= ST_LEAD;
            cnt      <= '0;
            pLast    <= pLastNext;
            halfLast <= DIV_W'(halfNext - (DIV_W+1)'(1));
            lastIdx  <= lastIdxNext;
            bitIdx   <= '0;
          end
        end
        ST_LEAD: begin
          cnt <= atEnd ? '0 : cnt + DIV_W'(1);
          if (atEnd) state <= ST_BITS;
        end
        ST_BITS: begin
          cnt <= atEnd ? '0 : cnt + DIV_W'(1);
          if (atEnd) begin
            if (bitIdx == lastIdx) state <= ST_TRAIL;
            else bitIdx <= bitIdx + IDX_W'(1);
          end
        end
        default: begin
          cnt <= atEnd ? '0 : cnt + DIV_W'(1);
          if (atEnd) state <= ST_IDLE;
        end
      endcase
    end
  end

  // Period counter stays inside the bit period
  assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= pLast);

  // A start seen while busy leaves the sequencer busy
  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BITS && startStb) |=> (state != ST_IDLE && state != ST_LEAD));

endmodule

// File: rtl/spiEngineDatapath.sv
module spiEngineDatapath
  import spiEnginePkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int RESP_W  = 24,
  parameter int NUM_TGT = 4,
  parameter int TGT_W   = $clog2(NUM_TGT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  engStrobes_t        stb,
  input  logic [DATA_W-1:0]  startData,
  input  logic               mosiOnRise,
  input  logic               misoOnRise,
  input  logic [TGT_W-1:0]   targetSel,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic [NUM_TGT-1:0] csN,
  output logic [RESP_W-1:0]  response
);

  logic [DATA_W-1:0] txShift;
  logic [RESP_W-1:0] rxShift;
  logic              mosiRiseQ;
  logic              misoRiseQ;
  logic              csActive;
  logic              shiftTx;
  logic              captureRx;

  always_comb begin
    shiftTx   = (stb.rise && mosiRiseQ && !stb.leadRise) ||
                (stb.fall && !mosiRiseQ && !stb.lastBit);
    captureRx = (stb.rise && misoRiseQ) || (stb.fall && !misoRiseQ);
  end

  assign mosi = csActive & txShift[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift   <= '0;
      rxShift   <= '0;
      mosiRiseQ <= 1'b0;
      misoRiseQ <= 1'b0;
      csActive  <= 1'b0;
      sclk      <= 1'b0;
      response  <= '0;
    end else begin
      if (stb.load) begin
        txShift   <= startData;
        rxShift   <= '0;
        mosiRiseQ <= mosiOnRise;
        misoRiseQ <= misoOnRise;
        csActive  <= 1'b1;
      end else begin
        if (shiftTx)   txShift <= {txShift[DATA_W-2:0], 1'b0};
        if (captureRx) rxShift <= {rxShift[RESP_W-2:0], miso};
      end
      if (stb.rise)      sclk <= 1'b1;
      else if (stb.fall) sclk <= 1'b0;
      if (stb.finish) begin
        csActive <= 1'b0;
        response <= rxShift;
      end
    end
  end

  // One chip-select flop per target
  for (genvar t = 0; t < NUM_TGT; t++) begin : gen_cs
    always_ff @(posedge clk) begin
      if (!rstN)           csN[t] <= 1'b1;
      else if (stb.load)   csN[t] <= (targetSel != TGT_W'(t));
      else if (stb.finish) csN[t] <= 1'b1;
    end
  end

  assert_sclk_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (csN == '1) |-> (!sclk && !mosi));

  assert_rise_inside_cs_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> (csN != '1));

endmodule

// File: rtl/spiEngine.sv
module spiEngine
  import spiEnginePkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int RESP_W  = 24,
  parameter int DIV_W   = 16,
  parameter int LEN_W   = 6,
  parameter int NUM_TGT = 4,
  localparam int TGT_W  = $clog2(NUM_TGT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startStb,
  input  logic [DATA_W-1:0]  startData,
  input  logic [DIV_W-1:0]   clkDiv,
  input  logic [LEN_W-1:0]   xferLen,
  input  logic               mosiOnRise,
  input  logic               misoOnRise,
  input  logic [TGT_W-1:0]   targetSel,
  output logic               sclk,
  output logic               mosi,
  output logic [NUM_TGT-1:0] csN,
  input  logic               miso,
  output logic               ready,
  output logic [RESP_W-1:0]  response
);

  engStrobes_t stb;

  spiEngineCtrl #(
    .DIV_W (DIV_W),
    .LEN_W (LEN_W),
    .DATA_W(DATA_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .startStb(startStb),
    .clkDiv  (clkDiv),
    .xferLen (xferLen),
    .ready   (ready),
    .stb     (stb)
  );

  spiEngineDatapath #(
    .DATA_W (DATA_W),
    .RESP_W (RESP_W),
    .NUM_TGT(NUM_TGT),
    .TGT_W  (TGT_W)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .startData (startData),
    .mosiOnRise(mosiOnRise),
    .misoOnRise(misoOnRise),
    .targetSel (targetSel),
    .miso      (miso),
    .sclk      (sclk),
    .mosi      (mosi),
    .csN       (csN),
    .response  (response)
  );

  assert_one_target_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rstN)
    (csN != '1) |-> !ready);

  assert_resp_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ready && $past(ready)) |-> $stable(response));

endmodule

// File: tb/sim_spiEngine.sv
module sim_spiEngine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startStb = 1'b0;
  logic [31:0] startData = '0;
  logic [15:0] clkDiv = '0;
  logic [5:0]  xferLen = '0;
  logic        mosiOnRise = 1'b0;
  logic        misoOnRise = 1'b0;
  logic [1:0]  targetSel = '0;
  logic        sclk;
  logic        mosi;
  logic [3:0]  csN;
  logic        miso = 1'b0;
  logic        ready;
  logic [23:0] response;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  spiEngine u0 (
    .clk(clk), .rstN(rstN), .startStb(startStb), .startData(startData),
    .clkDiv(clkDiv), .xferLen(xferLen), .mosiOnRise(mosiOnRise),
    .misoOnRise(misoOnRise), .targetSel(targetSel), .sclk(sclk), .mosi(mosi),
    .csN(csN), .miso(miso), .ready(ready), .response(response)
  );

  typedef struct {
    logic [31:0] tx;
    int          n;
    int          p;
    int          h;
    int          tgt;
    bit          mRise;
    bit          sRise;
    logic [31:0] slaveWord;
    logic [23:0] respExp;
  } item_t;

  item_t expQ[$];

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doXfer(input int div, input int len, input bit mr, input bit sr,
                        input int tgt, input logic [31:0] tx, input logic [31:0] sw,
                        input bit busyPoke);
    item_t it;
    logic [31:0] mask;
    it.n = (len == 0 || len > 32) ? 32 : len;
    it.p = (div == 0) ? 2 : div + 1;
    it.h = it.p / 2;
    it.tgt = tgt; it.tx = tx; it.mRise = mr; it.sRise = sr; it.slaveWord = sw;
    mask = (it.n == 32) ? 32'hFFFF_FFFF : ((32'd1 << it.n) - 32'd1);
    it.respExp = 24'(sw & mask);
    while (!ready) @(negedge clk);
    expQ.push_back(it);
    startData = tx; clkDiv = 16'(div); xferLen = 6'(len);
    mosiOnRise = mr; misoOnRise = sr; targetSel = 2'(tgt);
    startStb = 1'b1;
    @(negedge clk);
    startStb = 1'b0;
    check("R7", "ready after start", ready, 0);
    if (busyPoke) begin
      repeat (12) @(negedge clk);
      startData = ~tx; targetSel = 2'(tgt + 1); xferLen = 6'd3;
      startStb = 1'b1;
      @(negedge clk);
      startStb = 1'b0;
    end
    while (expQ.size() != 0 || !ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor and target model
  initial begin : monitor
    logic [3:0]  prevCs = 4'hF;
    logic        prevSclk = 1'b0;
    bit          active = 0;
    item_t       cur;
    int          lowCnt = 0, firstRise = 0, rises = 0, hiCnt = 0, idx = 0;
    logic [31:0] got = '0;
    forever begin
      @(negedge clk);
      if (!rstN) begin prevCs = 4'hF; prevSclk = 1'b0; active = 0; continue; end
      if (prevCs == 4'hF && csN != 4'hF) begin
        if (expQ.size() == 0) begin
          check("R7", "unexpected transfer while busy", 1, 0);
          active = 0;
        end else begin
          cur = expQ[0]; active = 1;
          lowCnt = 0; firstRise = 0; rises = 0; hiCnt = 0; got = '0;
          check("R8", "chip select pattern", csN, 4'hF & ~(4'd1 << cur.tgt));
          if (cur.sRise) begin miso = cur.slaveWord[cur.n-1]; idx = 1; end
          else idx = 0;
        end
      end
      if (active && csN != 4'hF) begin
        lowCnt++;
        if (sclk && !prevSclk) begin
          rises++;
          if (rises == 1) firstRise = lowCnt;
          if (!cur.mRise) got = {got[30:0], mosi};
          if (!cur.sRise) begin
            miso = (idx < cur.n) ? cur.slaveWord[cur.n-1-idx] : 1'b0; idx++;
          end
        end
        if (!sclk && prevSclk) begin
          if (cur.mRise) got = {got[30:0], mosi};
          if (cur.sRise) begin
            miso = (idx < cur.n) ? cur.slaveWord[cur.n-1-idx] : 1'b0; idx++;
          end
        end
        if (sclk && rises == 1) hiCnt++;
      end
      if (active && prevCs != 4'hF && csN == 4'hF) begin
        check("R9", "lead cycles to first rise", firstRise, cur.p + 1);
        check("R9", "rising edge count", rises, cur.n);
        check("R9", "chip select low cycles", lowCnt, (cur.n + 2) * cur.p);
        check("R2", "first high time", hiCnt, cur.h);
        check("R3", "MOSI bits (R4 edge)", got & ((cur.n == 32) ? 32'hFFFF_FFFF : ((32'd1 << cur.n) - 1)),
              cur.tx >> (32 - cur.n));
        check("R7", "ready at release", ready, 1);
        check("R6", "response (R5 capture)", response, cur.respExp);
        void'(expQ.pop_front());
        active = 0;
      end
      if (csN == 4'hF && rstN) begin
        if (sclk !== 1'b0 || mosi !== 1'b0) check("R10", "idle sclk/mosi", {sclk, mosi}, 0);
      end
      prevCs = csN; prevSclk = sclk;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    check("R1", "ready in reset", ready, 1);
    check("R1", "csN in reset", csN, 4'hF);
    check("R1", "sclk in reset", sclk, 0);
    check("R1", "mosi in reset", mosi, 0);
    check("R1", "response in reset", response, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "ready after reset", ready, 1);

    // R3 R4 R5: short, fall-launch, rise-capture
    doXfer(3, 8, 0, 1, 0, 32'hA5C3_0F01, 32'h0000_005A, 0);
    // R3: length 0 means 32; R2: divider 0 as 1
    doXfer(0, 0, 1, 0, 3, 32'hDEAD_BEEF, 32'h1234_5678, 0);
    // R6: 24 bits, both rising
    doXfer(4, 24, 1, 1, 1, 32'h8123_4567, 32'h00C0_FFEE, 0);
    // R3: length above 32 clamps, both falling, odd period
    doXfer(2, 40, 0, 0, 2, 32'h7F00_00FE, 32'hF0F0_1234, 0);
    // single bit
    doXfer(1, 1, 1, 1, 1, 32'h8000_0000, 32'h0000_0001, 0);
    doXfer(5, 12, 0, 1, 3, 32'hFFF0_0000, 32'h0000_0ABC, 0);
    // R7: start while busy is ignored
    doXfer(7, 16, 0, 1, 0, 32'h5A5A_0000, 32'h0000_9669, 1);
    @(negedge clk);
    check("R6", "response held in idle", response, 24'h009669);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule